// File: doc/BRIEF.md
# Planar YUV 4:2:0 to Packed YUYV Converter

This block turns one frame of planar 4:2:0 video into packed YUYV 4:2:2 lines. The luma plane and the two chroma planes each live at their own base address in byte-addressed memory. After a start command the block fetches bytes one at a time over a read request/response port. It interleaves each pair of pixels into a single 32-bit group and writes that group through a write port. Each output line begins at the output base plus the line number times a programmable pitch.

Each chroma row serves two luma rows, because chroma is subsampled both across and down. Input luma rows may carry trailing padding bytes. The chroma row stride is half the luma stride. Output lines may be spaced further apart than the converted data needs. The bytes between the end of one line's data and the start of the next line are never written. Configuration is sampled when a frame starts. A one-cycle done pulse marks the end of the frame. A frame whose width or height is odd or zero is refused, and an error flag is raised.

Top module: `yuyv_packer`

## Requirements
- R1: Every output word holds one pixel pair n of a line as bytes Y[2n] in bits 7:0, U[n] in bits 15:8, Y[2n+1] in bits 23:16 and V[n] in bits 31:24.
- R2: Luma rows 2k and 2k+1 both read chroma row k. Chroma row k starts at the U (or V) base plus k times (width + input padding) / 2, and pair n reads byte n of that row.
- R3: Luma row r starts at the Y base plus r times (width + input padding), and pixel x of that row is read at that start plus x.
- R4: Word n of output line r is written at the output base plus r times pitch plus 4n. Exactly width/2 words are written per line and height lines per frame, so pitch bytes past 2×width are never written.
- R5: For each pixel pair, read requests are issued in the order Y[2n], U[n], Y[2n+1], V[n], with one request outstanding at a time. No read is requested while a write is pending.
- R6: While rdReq is high and rdReady is low, rdReq and rdAddr hold. While wrValid is high and wrReady is low, wrValid, wrAddr and wrData hold.
- R7: done is high for exactly one cycle: the cycle after the last word of the last line is accepted. busy is low from then on.
- R8: A start with an odd or zero width or height starts no frame. No read or write is issued, busy stays low and err goes high. err is cleared by the next start with valid dimensions.
- R9: A start while busy is ignored. All configuration inputs are sampled at the accepted start, and later changes do not affect the running frame.
- R10: After reset, busy, done, err, rdReq and wrValid are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start one frame (accepted only when idle) |
| cfgWidth | input | DIM_W | Frame width in pixels (even, non-zero) |
| cfgHeight | input | DIM_W | Frame height in lines (even, non-zero) |
| cfgInPad | input | DIM_W | Padding bytes after each luma input row |
| cfgPitch | input | ADDR_W | Output line pitch in bytes |
| yBase | input | ADDR_W | Luma plane base address |
| uBase | input | ADDR_W | U plane base address |
| vBase | input | ADDR_W | V plane base address |
| outBase | input | ADDR_W | Output frame base address |
| rdReq | output | 1 | Read request valid |
| rdAddr | output | ADDR_W | Read byte address |
| rdReady | input | 1 | Read port accepts the request |
| rdValid | input | 1 | Read response valid |
| rdData | input | 8 | Read response byte |
| wrValid | output | 1 | Write word valid |
| wrAddr | output | ADDR_W | Write byte address of the word |
| wrData | output | 32 | Packed Y-U-Y-V word |
| wrReady | input | 1 | Write port accepts the word |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| err | output | 1 | Last start had invalid dimensions |

## Verification
The bench logs every accepted read address and every accepted write. It compares them with sequences rebuilt from the stride rules. A design that advanced the chroma row on every luma line, or used the full luma stride for chroma, would show wrong U/V addresses in the second luma row of a pair. A design that used the pitch as the data length would write into the padding gap. Random-looking ready stalls on both ports expose a design that drops or repeats a byte when a handshake is held off. Stalls also expose a done pulse that fires before the last word is taken. Odd, zero and mid-frame starts catch a design that launches a broken frame or re-reads its configuration while running.

// File: rtl/yuyv_pkg.sv
package yuyv_pkg;

  typedef enum logic [1:0] {
    PH_Y0 = 2'd0,
    PH_U  = 2'd1,
    PH_Y1 = 2'd2,
    PH_V  = 2'd3
  } phase_e;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_REQ   = 2'd1,
    S_WAIT  = 2'd2,
    S_WRITE = 2'd3
  } state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic   load;
    logic   capture;
    phase_e phase;
    logic   nextPair;
    logic   nextLine;
  } strobes_t;

  // position flags from datapath to control
  typedef struct packed {
    logic lastPair;
    logic lastLine;
  } pos_t;

endpackage

// File: rtl/yuyv_ctrl.sv
module yuyv_ctrl
  import yuyv_pkg::*;
#(
  parameter int DIM_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [DIM_W-1:0] cfgWidth,
  input  logic [DIM_W-1:0] cfgHeight,
  input  logic             rdReady,
  input  logic             rdValid,
  input  logic             wrReady,
  input  pos_t             pos,
  output strobes_t         stb,
  output logic             rdReq,
  output logic             wrValid,
  output logic             busy,
  output logic             done,
  output logic             err
);

  state_e state;
  phase_e phaseR;
  logic   cfgOk;
  logic   frameEnd;
  logic   wordTaken;

  assign cfgOk = (cfgWidth != '0) && (cfgHeight != '0) &&
                 !cfgWidth[0] && !cfgHeight[0];

  assign rdReq     = (state == S_REQ);
  assign wrValid   = (state == S_WRITE);
  assign busy      = (state != S_IDLE);
  assign wordTaken = (state == S_WRITE) && wrReady;
  assign frameEnd  = wordTaken && pos.lastPair && pos.lastLine;

  always_comb begin
    stb          = '0;
    stb.phase    = phaseR;
    stb.load     = (state == S_IDLE) && start && cfgOk;
    stb.capture  = (state == S_WAIT) && rdValid;
    if (wordTaken && !frameEnd) begin
      if (pos.lastPair) stb.nextLine = 1'b1;
      else              stb.nextPair = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= S_IDLE;
      phaseR <= PH_Y0;
      done   <= 1'b0;
      err    <= 1'b0;
    end else begin
      done <= frameEnd;
      unique case (state)
        S_IDLE: begin
          if (start) begin
            err <= !cfgOk;
            if (cfgOk) begin
              state  <= S_REQ;
              phaseR <= PH_Y0;
            end
          end
        end
        S_REQ: begin
          if (rdReady) state <= S_WAIT;
        end
        S_WAIT: begin
          if (rdValid) begin
            if (phaseR == PH_V) begin
              state <= S_WRITE;
            end else begin
              state  <= S_REQ;
              phaseR <= phase_e'(phaseR + 2'd1);
            end
          end
        end
        S_WRITE: begin
          if (wrReady) begin
            phaseR <= PH_Y0;
            state  <= frameEnd ? S_IDLE : S_REQ;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/yuyv_dpath.sv
module yuyv_dpath
  import yuyv_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DIM_W  = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          stb,
  input  logic [DIM_W-1:0]  cfgWidth,
  input  logic [DIM_W-1:0]  cfgHeight,
  input  logic [DIM_W-1:0]  cfgInPad,
  input  logic [ADDR_W-1:0] cfgPitch,
  input  logic [ADDR_W-1:0] yBase,
  input  logic [ADDR_W-1:0] uBase,
  input  logic [ADDR_W-1:0] vBase,
  input  logic [ADDR_W-1:0] outBase,
  input  logic [7:0]        rdData,
  output pos_t              pos,
  output logic [ADDR_W-1:0] rdAddr,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [31:0]       wrData
);

  // frame settings captured at start
  logic [DIM_W-1:0]  widthR, heightR, padR;
  logic [ADDR_W-1:0] pitchR, uBaseR, vBaseR;
  // walking pointers
  logic [DIM_W-1:0]  pairIdx, rowIdx;
  logic [ADDR_W-1:0] yRow, cRow, oRow;
  // gathered bytes of the current pair
  logic [7:0] y0B, uB, y1B, vB;

  logic [ADDR_W-1:0] lumaStride, chromaStride, pairOff, lumaOff;

  assign lumaStride   = ADDR_W'(widthR) + ADDR_W'(padR);
  assign chromaStride = lumaStride >> 1;
  assign pairOff      = ADDR_W'(pairIdx);
  assign lumaOff      = pairOff << 1;

  assign pos.lastPair = (pairIdx == (widthR >> 1) - DIM_W'(1));
  assign pos.lastLine = (rowIdx == heightR - DIM_W'(1));

  always_comb begin
    unique case (stb.phase)
      PH_Y0:   rdAddr = yRow + lumaOff;
      PH_U:    rdAddr = uBaseR + cRow + pairOff;
      PH_Y1:   rdAddr = yRow + lumaOff + ADDR_W'(1);
      default: rdAddr = vBaseR + cRow + pairOff;
    endcase
  end

  assign wrAddr = oRow + (pairOff << 2);
  assign wrData = {vB, y1B, uB, y0B};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      widthR  <= '0;
      heightR <= '0;
      padR    <= '0;
      pitchR  <= '0;
      uBaseR  <= '0;
      vBaseR  <= '0;
      pairIdx <= '0;
      rowIdx  <= '0;
      yRow    <= '0;
      cRow    <= '0;
      oRow    <= '0;
    end else if (stb.load) begin
      widthR  <= cfgWidth;
      heightR <= cfgHeight;
      padR    <= cfgInPad;
      pitchR  <= cfgPitch;
      uBaseR  <= uBase;
      vBaseR  <= vBase;
      pairIdx <= '0;
      rowIdx  <= '0;
      yRow    <= yBase;
      cRow    <= '0;
      oRow    <= outBase;
    end else if (stb.nextLine) begin
      pairIdx <= '0;
      rowIdx  <= rowIdx + DIM_W'(1);
      yRow    <= yRow + lumaStride;
      oRow    <= oRow + pitchR;
      if (rowIdx[0]) cRow <= cRow + chromaStride;
    end else if (stb.nextPair) begin
      pairIdx <= pairIdx + DIM_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      y0B <= '0;
      uB  <= '0;
      y1B <= '0;
      vB  <= '0;
    end else if (stb.capture) begin
      unique case (stb.phase)
        PH_Y0:   y0B <= rdData;
        PH_U:    uB  <= rdData;
        PH_Y1:   y1B <= rdData;
        default: vB  <= rdData;
      endcase
    end
  end

endmodule

// File: rtl/yuyv_packer.sv
module yuyv_packer
  import yuyv_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DIM_W  = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [DIM_W-1:0]  cfgWidth,
  input  logic [DIM_W-1:0]  cfgHeight,
  input  logic [DIM_W-1:0]  cfgInPad,
  input  logic [ADDR_W-1:0] cfgPitch,
  input  logic [ADDR_W-1:0] yBase,
  input  logic [ADDR_W-1:0] uBase,
  input  logic [ADDR_W-1:0] vBase,
  input  logic [ADDR_W-1:0] outBase,
  output logic              rdReq,
  output logic [ADDR_W-1:0] rdAddr,
  input  logic              rdReady,
  input  logic              rdValid,
  input  logic [7:0]        rdData,
  output logic              wrValid,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [31:0]       wrData,
  input  logic              wrReady,
  output logic              busy,
  output logic              done,
  output logic              err
);

  strobes_t stb;
  pos_t     pos;

  yuyv_ctrl #(.DIM_W(DIM_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .cfgWidth (cfgWidth),
    .cfgHeight(cfgHeight),
    .rdReady  (rdReady),
    .rdValid  (rdValid),
    .wrReady  (wrReady),
    .pos      (pos),
    .stb      (stb),
    .rdReq    (rdReq),
    .wrValid  (wrValid),
    .busy     (busy),
    .done     (done),
    .err      (err)
  );

  yuyv_dpath #(.ADDR_W(ADDR_W), .DIM_W(DIM_W)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .cfgWidth (cfgWidth),
    .cfgHeight(cfgHeight),
    .cfgInPad (cfgInPad),
    .cfgPitch (cfgPitch),
    .yBase    (yBase),
    .uBase    (uBase),
    .vBase    (vBase),
    .outBase  (outBase),
    .rdData   (rdData),
    .pos      (pos),
    .rdAddr   (rdAddr),
    .wrAddr   (wrAddr),
    .wrData   (wrData)
  );

endmodule

// File: rtl/yuyv_packer_chk.sv
module yuyv_packer_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              rdReq,
  input logic [ADDR_W-1:0] rdAddr,
  input logic              rdReady,
  input logic              wrValid,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [31:0]       wrData,
  input logic              wrReady,
  input logic              busy,
  input logic              done,
  input logic              err
);

  a_r6_rd_hold: assert property (@(posedge clk) disable iff (!rstN)
    rdReq && !rdReady |=> rdReq && $stable(rdAddr));

  a_r6_wr_hold: assert property (@(posedge clk) disable iff (!rstN)
    wrValid && !wrReady |=> wrValid && $stable(wrAddr) && $stable(wrData));

  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r7_done_after_word: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(wrValid && wrReady) && !busy);

  a_r5_one_port: assert property (@(posedge clk) disable iff (!rstN)
    !(rdReq && wrValid));

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !rdReq && !wrValid);

  a_r8_err_idle: assert property (@(posedge clk) disable iff (!rstN)
    err |-> !busy);

endmodule

bind yuyv_packer yuyv_packer_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .rdReq  (rdReq),
  .rdAddr (rdAddr),
  .rdReady(rdReady),
  .wrValid(wrValid),
  .wrAddr (wrAddr),
  .wrData (wrData),
  .wrReady(wrReady),
  .busy   (busy),
  .done   (done),
  .err    (err)
);

// File: tb/test_yuyv_packer.sv
module test_yuyv_packer;

  localparam int ADDR_W = 32;
  localparam int DIM_W  = 12;
  localparam logic [31:0] Y_B = 32'h0000_1000;
  localparam logic [31:0] U_B = 32'h0000_2000;
  localparam logic [31:0] V_B = 32'h0000_3000;
  localparam logic [31:0] O_B = 32'h0000_8000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [DIM_W-1:0] cfgWidth = '0, cfgHeight = '0, cfgInPad = '0;
  logic [31:0] cfgPitch = '0, yBase = Y_B, uBase = U_B, vBase = V_B, outBase = O_B;
  logic rdReq, rdReady = 1'b1, rdValid = 1'b0;
  logic [31:0] rdAddr;
  logic [7:0] rdData = '0;
  logic wrValid, wrReady = 1'b1;
  logic [31:0] wrAddr, wrData;
  logic busy, done, err;

  yuyv_packer #(.ADDR_W(ADDR_W), .DIM_W(DIM_W)) i_yuyv_packer (
    .clk(clk), .rstN(rstN), .start(start),
    .cfgWidth(cfgWidth), .cfgHeight(cfgHeight), .cfgInPad(cfgInPad),
    .cfgPitch(cfgPitch), .yBase(yBase), .uBase(uBase), .vBase(vBase),
    .outBase(outBase), .rdReq(rdReq), .rdAddr(rdAddr), .rdReady(rdReady),
    .rdValid(rdValid), .rdData(rdData), .wrValid(wrValid), .wrAddr(wrAddr),
    .wrData(wrData), .wrReady(wrReady), .busy(busy), .done(done), .err(err)
  );

  always #4 clk = ~clk;

  int tests = 0;
  int fails = 0;

  // memory image: a byte depends on both address bytes so planes differ
  function automatic logic [7:0] memByte(input logic [31:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  // bus model and monitors, all at the falling edge
  int          negCnt = 0;
  bit          stallOn = 0;
  bit          pend = 0;
  logic [31:0] pendAddr = '0;
  logic [31:0] rdLog [256];
  logic [31:0] wrAddrLog [256];
  logic [31:0] wrDataLog [256];
  int          rdCnt = 0, wrCnt = 0, doneCnt = 0;
  int          lastWrNeg = 0, doneNeg = 0, holdErr = 0;
  bit          prevRdStall = 0, prevWrStall = 0;
  logic [31:0] prevRdAddr = '0, prevWrAddr = '0, prevWrData = '0;

  always @(negedge clk) begin
    negCnt++;
    rdValid = 1'b0;
    if (pend) begin
      rdValid = 1'b1;
      rdData  = memByte(pendAddr);
      pend    = 0;
    end
    rdReady = stallOn ? (negCnt % 3 != 0) : 1'b1;
    wrReady = stallOn ? (negCnt % 2 == 0) : 1'b1;
    if (prevRdStall && (!rdReq || rdAddr != prevRdAddr)) holdErr++;
    if (prevWrStall && (!wrValid || wrAddr != prevWrAddr || wrData != prevWrData)) holdErr++;
    prevRdStall = rdReq && !rdReady;
    prevWrStall = wrValid && !wrReady;
    prevRdAddr  = rdAddr;
    prevWrAddr  = wrAddr;
    prevWrData  = wrData;
    if (rdReq && rdReady) begin
      if (rdCnt < 256) rdLog[rdCnt] = rdAddr;
      rdCnt++;
      pend     = 1;
      pendAddr = rdAddr;
    end
    if (wrValid && wrReady) begin
      if (wrCnt < 256) begin
        wrAddrLog[wrCnt] = wrAddr;
        wrDataLog[wrCnt] = wrData;
      end
      wrCnt++;
      lastWrNeg = negCnt;
    end
    if (done) begin
      doneCnt++;
      doneNeg = negCnt;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clearLogs();
    rdCnt = 0; wrCnt = 0; doneCnt = 0; holdErr = 0;
  endtask

  task automatic pulseStart();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // run one frame and compare every read and write with the stride rules
  task automatic runFrame(input int w, input int h, input int p, input int pitch,
                          input bit midStart);
    int pairs, idx, lstride, cstride;
    logic [31:0] yr, cr, a0, au, a1, av, ea;
    clearLogs();
    cfgWidth = DIM_W'(w); cfgHeight = DIM_W'(h); cfgInPad = DIM_W'(p);
    cfgPitch = pitch; yBase = Y_B; uBase = U_B; vBase = V_B; outBase = O_B;
    pulseStart();
    if (midStart) begin
      // R9: change every setting and start again while running
      repeat (5) @(negedge clk);
      cfgWidth = 12'd8; cfgHeight = 12'd4; cfgInPad = 12'd2; cfgPitch = 32'd64;
      yBase = 32'h4000; uBase = 32'h5000; vBase = 32'h6000; outBase = 32'h9000;
      pulseStart();
      chk(busy == 1'b1, "R9", "still busy after mid-frame start", busy, 1);
    end
    for (int t = 0; t < 20000 && doneCnt == 0; t++) @(negedge clk);
    repeat (4) @(negedge clk);

    pairs   = (w / 2) * h;
    lstride = w + p;
    cstride = lstride / 2;
    chk(rdCnt == pairs * 4, "R5", "read count", rdCnt, pairs * 4);
    chk(wrCnt == pairs, "R4", "write count", wrCnt, pairs);
    for (int r = 0; r < h; r++) begin
      yr = Y_B + r * lstride;
      cr = (r / 2) * cstride;
      for (int n = 0; n < w / 2; n++) begin
        idx = r * (w / 2) + n;
        a0 = yr + 2 * n;
        a1 = yr + 2 * n + 1;
        au = U_B + cr + n;
        av = V_B + cr + n;
        ea = O_B + r * pitch + 4 * n;
        if (idx * 4 + 3 < 256 && idx < rdCnt / 4) begin
          chk(rdLog[idx*4]   == a0, "R3", "luma even read", rdLog[idx*4], a0);
          chk(rdLog[idx*4+1] == au, "R2", "U read", rdLog[idx*4+1], au);
          chk(rdLog[idx*4+2] == a1, "R3", "luma odd read", rdLog[idx*4+2], a1);
          chk(rdLog[idx*4+3] == av, "R2", "V read", rdLog[idx*4+3], av);
        end
        if (idx < 256 && idx < wrCnt) begin
          chk(wrAddrLog[idx] == ea, "R4", "write address", wrAddrLog[idx], ea);
          chk(wrDataLog[idx] == {memByte(av), memByte(a1), memByte(au), memByte(a0)},
              "R1", "packed word", wrDataLog[idx],
              {memByte(av), memByte(a1), memByte(au), memByte(a0)});
        end
      end
    end
    chk(doneCnt == 1, "R7", "done pulse count", doneCnt, 1);
    chk(doneNeg == lastWrNeg + 1, "R7", "done one cycle after last word",
        doneNeg, lastWrNeg + 1);
    chk(busy == 1'b0, "R7", "busy low after frame", busy, 0);
    chk(holdErr == 0, "R6", "handshake hold violations", holdErr, 0);
  endtask

  task automatic t_reset();
    chk(busy == 0 && done == 0 && err == 0 && rdReq == 0 && wrValid == 0,
        "R10", "outputs after reset",
        {busy, done, err, rdReq, wrValid}, 0);
  endtask

  task automatic t_basic();   // R1 R3 R4: padded output pitch
    stallOn = 0;
    runFrame(8, 2, 0, 48, 0);
  endtask

  task automatic t_chroma();  // R2: chroma row sharing with input padding
    stallOn = 0;
    runFrame(4, 4, 4, 8, 0);
  endtask

  task automatic t_stall();   // R6 R5 under back-pressure
    stallOn = 1;
    runFrame(6, 2, 2, 16, 0);
    stallOn = 0;
  endtask

  task automatic t_busyStart(); // R9
    stallOn = 0;
    runFrame(4, 2, 0, 12, 1);
  endtask

  task automatic badStart(input int w, input int h, input string what);
    clearLogs();
    cfgWidth = DIM_W'(w); cfgHeight = DIM_W'(h); cfgInPad = '0; cfgPitch = 32'd16;
    pulseStart();
    repeat (10) @(negedge clk);
    chk(err == 1'b1, "R8", {what, " err"}, err, 1);
    chk(busy == 1'b0 && rdCnt == 0 && wrCnt == 0 && doneCnt == 0, "R8",
        {what, " no activity"}, rdCnt + wrCnt + doneCnt + busy, 0);
  endtask

  task automatic t_err();     // R8
    badStart(5, 2, "odd width");
    badStart(4, 3, "odd height");
    badStart(0, 2, "zero width");
    stallOn = 0;
    runFrame(2, 2, 0, 4, 0);
    chk(err == 1'b0, "R8", "err cleared by valid start", err, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_chroma();
    t_stall();
    t_busyStart();
    t_err();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule